// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit effective address of an indexed operand for an 8-bit processor core whose index registers are 16 bits wide. The caller presents a 4-bit mode code, an indirect flag, the already selected base register, both accumulators and the program counter, then pulses `start`. The block adds the offset that the mode calls for to the base. That offset may be an accumulator, the accumulator pair, or one or two inline bytes fetched at the program counter. It then optionally follows the result as a pointer. The final address comes back with a one-cycle `done` pulse.

Memory is reached through a byte-wide read port with combinational return data, one read per clock. Words in memory are big-endian: the high byte sits at the lower address. The program counter that was advanced past any inline offset bytes is returned on `pc_out`, so the caller can continue its fetch from there.

Top module: `idx_ea_gen`

## Requirements
- R1: After reset `done`, `busy` and `mem_rd` are 0.
- R2: Mode 5 gives base + B, with B sign-extended from 8 to 16 bits, modulo 2^16.
- R3: Mode 6 gives base + A, with A sign-extended from 8 to 16 bits, modulo 2^16.
- R4: Mode 11 gives base + {A,B}, with A as the high byte, modulo 2^16.
- R5: Mode 8 reads one byte at the PC, gives base + that byte sign-extended, and returns PC+1 on `pc_out`.
- R6: Mode 9 reads a 16-bit offset at the PC, high byte first at PC and low byte at PC+1. It gives base + offset modulo 2^16 and returns PC+2.
- R7: Modes 12 (8-bit signed offset) and 13 (16-bit offset) use as base the PC after the offset bytes: PC+1+sext(byte) and PC+2+word respectively.
- R8: With `indirect` set, the computed address is a pointer. The result is {mem[p], mem[p+1]}, read in that order.
- R9: Mode 4 and the unassigned codes 0-3, 7, 10, 14 and 15 give the base unchanged and do no reads.
- R10: `done` is high for exactly one cycle per accepted request. A `start` while `busy` is ignored. Modes without inline bytes return the input PC on `pc_out`.
- R11: `done` rises 2 cycles after the accepted `start` edge. It comes 1 cycle later for each inline offset byte and 2 cycles later when indirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Offset mode code |
| indirect | input | 1 | Follow computed address as pointer |
| base | input | 16 | Selected index register value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_in | input | 16 | Program counter at the first offset byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_data | input | 8 | Read data, valid in the same cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address, valid with `done` |
| pc_out | output | 16 | Program counter after offset bytes |

## Verification
Random requests cover every mode code with and without indirection, over random bases, accumulators and PCs, against a memory whose bytes are a function of the address. Negative accumulator and offset values show whether sign extension is applied. Mode 9 and mode 11, given values that wrap past 0xFFFF, show that no sign handling is applied. The two PC-relative modes show whether the post-fetch PC is used. Read counts and latency separate the fetch paths from one another, and a second start injected mid-request shows whether inputs are latched.

// File: rtl/idx_ea_gen.sv
module idx_ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic        indirect,
  input  logic [15:0] base,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  acc_b,
  input  logic [15:0] pc_in,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [15:0] pc_out
);
  typedef enum logic [2:0] {S_IDLE, S_OFF1, S_OFF2, S_ADD, S_PTR1, S_PTR2} st_t;
  st_t st;

  logic [3:0]  r_mode;
  logic        r_ind;
  logic [15:0] r_base, r_pc, r_off, ea_r;
  logic [7:0]  r_a, r_b, ptr_hi;

  wire in_b8   = (mode == 4'd8) || (mode == 4'd12);
  wire in_b16  = (mode == 4'd9) || (mode == 4'd13);
  wire r_b16   = (r_mode == 4'd9) || (r_mode == 4'd13);
  wire r_pcrel = (r_mode == 4'd12) || (r_mode == 4'd13);

  logic [15:0] offset;
  always_comb begin
    case (r_mode)
      4'd5:                      offset = {{8{r_b[7]}}, r_b};
      4'd6:                      offset = {{8{r_a[7]}}, r_a};
      4'd11:                     offset = {r_a, r_b};
      4'd8, 4'd9, 4'd12, 4'd13:  offset = r_off;
      default:                   offset = 16'h0000;
    endcase
  end

  wire [15:0] sum = (r_pcrel ? r_pc : r_base) + offset;

  assign busy     = (st != S_IDLE);
  assign mem_rd   = (st == S_OFF1) || (st == S_OFF2) || (st == S_PTR1) || (st == S_PTR2);
  assign mem_addr = (st == S_PTR1) ? ea_r : (st == S_PTR2) ? ea_r + 16'd1 : r_pc;
  assign ea       = ea_r;
  assign pc_out   = r_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      r_mode <= 4'd0;
      r_ind  <= 1'b0;
      r_base <= 16'h0;
      r_pc   <= 16'h0;
      r_off  <= 16'h0;
      r_a    <= 8'h0;
      r_b    <= 8'h0;
      ea_r   <= 16'h0;
      ptr_hi <= 8'h0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          r_mode <= mode;
          r_ind  <= indirect;
          r_base <= base;
          r_pc   <= pc_in;
          r_a    <= acc_a;
          r_b    <= acc_b;
          st     <= (in_b8 || in_b16) ? S_OFF1 : S_ADD;
        end
        S_OFF1: begin
          r_pc <= r_pc + 16'd1;
          if (r_b16) begin
            r_off[15:8] <= mem_data;
            st <= S_OFF2;
          end else begin
            r_off <= {{8{mem_data[7]}}, mem_data};
            st <= S_ADD;
          end
        end
        S_OFF2: begin
          r_pc       <= r_pc + 16'd1;
          r_off[7:0] <= mem_data;
          st         <= S_ADD;
        end
        S_ADD: begin
          ea_r <= sum;
          if (r_ind) st <= S_PTR1;
          else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_PTR1: begin
          ptr_hi <= mem_data;
          st     <= S_PTR2;
        end
        S_PTR2: begin
          ea_r <= {ptr_hi, mem_data};
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(r_mode) && $stable(r_base));
  p_ptr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PTR1) |=> mem_rd && (mem_addr == $past(mem_addr) + 16'd1));
  p_ptr_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PTR2) |=> done && (ea == {$past(ptr_hi), $past(mem_data)}));
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF1) |=> pc_out == $past(pc_out) + 16'd1);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && !done);
endmodule

// File: tb/idx_ea_gen_test.sv
module idx_ea_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = 4'd0;
  logic indirect = 1'b0;
  logic [15:0] base = 16'h0, pc_in = 16'h0;
  logic [7:0] acc_a = 8'h0, acc_b = 8'h0;
  logic mem_rd, busy, done;
  logic [15:0] mem_addr, ea, pc_out;
  logic [7:0] mem_data;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    mb = (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_data = mb(mem_addr);

  idx_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .indirect(indirect),
    .base(base), .acc_a(acc_a), .acc_b(acc_b), .pc_in(pc_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done), .ea(ea), .pc_out(pc_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [3:0] m);
    case (m)
      4'd5: mode_req = "R2";
      4'd6: mode_req = "R3";
      4'd11: mode_req = "R4";
      4'd8: mode_req = "R5";
      4'd9: mode_req = "R6";
      4'd12, 4'd13: mode_req = "R7";
      default: mode_req = "R9";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input bit ind, input logic [15:0] b,
                        input logic [7:0] a, input logic [7:0] bb, input logic [15:0] pc,
                        input bit poke);
    logic [15:0] off, bs, e, pce;
    int nbytes, cyc, reads, exp_cyc;
    bit got;
    nbytes = 0; pce = pc; bs = b;
    case (m)
      4'd5: off = {{8{bb[7]}}, bb};
      4'd6: off = {{8{a[7]}}, a};
      4'd11: off = {a, bb};
      4'd8, 4'd12: begin nbytes = 1; off = {{8{mb(pc)[7]}}, mb(pc)}; pce = pc + 16'd1; end
      4'd9, 4'd13: begin nbytes = 2; off = {mb(pc), mb(pc + 16'd1)}; pce = pc + 16'd2; end
      default: off = 16'h0;
    endcase
    if (m == 4'd12 || m == 4'd13) bs = pce;
    e = bs + off;
    if (ind) e = {mb(e), mb(e + 16'd1)};
    exp_cyc = 2 + nbytes + (ind ? 2 : 0);

    @(negedge clk);
    mode = m; indirect = ind; base = b; acc_a = a; acc_b = bb; pc_in = pc; start = 1'b1;
    cyc = 0; reads = 0; got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && poke) begin
        mode = ~m; base = ~b; pc_in = ~pc; acc_a = ~a; acc_b = ~bb; indirect = ~ind;
      end else start = 1'b0;
      if (mem_rd) reads++;
      if (done) begin got = 1; break; end
    end
    start = 1'b0;
    check(got, "R10 done seen", {31'd0, got}, 32'd1);
    check(ea == e, mode_req(m), {16'd0, ea}, {16'd0, e});
    if (ind) check(ea == e, "R8 indirect", {16'd0, ea}, {16'd0, e});
    check(pc_out == pce, (nbytes == 0) ? "R10 pc kept" : mode_req(m), {16'd0, pc_out}, {16'd0, pce});
    check(cyc == exp_cyc, "R11 latency", cyc, exp_cyc);
    check(reads == nbytes + (ind ? 2 : 0), (nbytes == 0 && !ind) ? "R9 reads" : "R11 reads",
          reads, nbytes + (ind ? 2 : 0));
    @(negedge clk);
    check(!done, "R10 pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_rd, "R1 reset", {29'd0, done, busy, mem_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !busy && !mem_rd, "R1 idle", {29'd0, done, busy, mem_rd}, 32'd0);

    run_op(4'd5, 0, 16'h0010, 8'h00, 8'h80, 16'h1000, 0);
    run_op(4'd5, 0, 16'h0010, 8'h00, 8'h7F, 16'h1000, 0);
    run_op(4'd6, 0, 16'h0005, 8'hFF, 8'h00, 16'h2000, 0);
    run_op(4'd11, 0, 16'hFFFF, 8'h80, 8'h01, 16'h3000, 0);
    run_op(4'd8, 0, 16'h4000, 8'h00, 8'h00, 16'h0003, 0);
    run_op(4'd9, 0, 16'hFFF0, 8'h00, 8'h00, 16'h0100, 0);
    run_op(4'd12, 0, 16'h0000, 8'h00, 8'h00, 16'hFFFF, 0);
    run_op(4'd13, 0, 16'h0000, 8'h00, 8'h00, 16'hFFFE, 0);
    run_op(4'd4, 0, 16'hABCD, 8'h12, 8'h34, 16'h5000, 0);
    run_op(4'd15, 0, 16'h1234, 8'h80, 8'h80, 16'h5000, 0);
    run_op(4'd7, 0, 16'h4321, 8'hFF, 8'hFF, 16'h5000, 0);
    run_op(4'd4, 1, 16'hFFFF, 8'h00, 8'h00, 16'h6000, 0);
    run_op(4'd9, 1, 16'h8000, 8'h00, 8'h00, 16'h7000, 1);
    run_op(4'd5, 0, 16'h0100, 8'h00, 8'hF0, 16'h7000, 1);

    for (int k = 0; k < 400; k++)
      run_op(4'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
             16'($urandom), (k % 7) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule